// File: doc/BRIEF.md
# Execute-Packet Fetch Address Sequencer

This block holds the address of the next execute packet that the fetch stage should present. It advances that address as packets dispatch, and it carries out conditional branches that have a fixed number of delay slots. It also enters an interrupt service routine and later returns from it. Other logic decides the branch condition and computes the target. The block receives a taken-branch event, together with its target, on the cycle the branching packet dispatches.

A taken branch loads a countdown. The next `SLOTS` dispatched packets run in sequence as delay slots. When the last of them dispatches, the fetch address becomes the stored target, exactly as it was supplied, aligned or not. An interrupt request waits until no delay slots are outstanding. It then discards the packet currently presented, saves that packet's address as the resume point, pulses a one-cycle flush and moves the fetch address to the vector. A return does the reverse. Interrupt entry and return act even while the pipeline is stalled. Ordinary dispatch and the countdown stand still during a stall.

Top module: `flow_seq`

## Requirements
- R1: While and after reset, `fetch_addr_o` equals the parameter `RESET_ADDR`, `ret_addr_o` is zero, and `flush_o` and `br_illegal_o` are low.
- R2: In a cycle with `disp_i` high, `stall_i` low and no interrupt entry or return, `fetch_addr_o` becomes its value plus `adv_i` (packet size in bytes) on the next cycle. With `disp_i` low it holds.
- R3: After a packet dispatches with `br_taken_i` high and no countdown running, the next `SLOTS` dispatched packets advance sequentially. The cycle after the last of them dispatches, `fetch_addr_o` equals `br_tgt_i` as captured, with no alignment applied.
- R4: While `stall_i` is high and no interrupt entry or return occurs, `fetch_addr_o` holds. The delay-slot countdown does not advance.
- R5: A taken branch that dispatches while a countdown is running raises `br_illegal_o` for one cycle and is otherwise ignored. The first branch's target still takes effect after its slots.
- R6: An interrupt request with no countdown running and no service in progress takes effect on the next edge. `flush_o` is high for that one cycle, `fetch_addr_o` equals the vector, and `ret_addr_o` equals the address that was presented. That packet is not counted as dispatched.
- R7: An interrupt request that arrives while delay slots are outstanding is held. It takes effect on the cycle after the countdown ends, and `ret_addr_o` then equals the branch target.
- R8: `irq_ret_i` during service produces a one-cycle `flush_o`, and `fetch_addr_o` becomes `ret_addr_o`. Outside service, `irq_ret_i` has no effect on `fetch_addr_o` or `flush_o`.
- R9: An interrupt request during service does not flush. It is accepted on the cycle after the return, with its own vector, and the resume address is taken at that point.
- R10: Interrupt entry and return take effect with `stall_i` high.
- R11: `flush_o` is high only on the single cycle after an entry or return, and falls on the next cycle unless a further event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Global pipeline stall |
| disp_i | input | 1 | Presented packet dispatches this cycle |
| adv_i | input | ADV_W | Byte size of the dispatching packet |
| br_taken_i | input | 1 | Dispatching packet holds a taken branch |
| br_tgt_i | input | ADDR_W | Branch target address |
| irq_req_i | input | 1 | Interrupt request pulse |
| irq_vec_i | input | ADDR_W | Interrupt service address |
| irq_ret_i | input | 1 | Return from interrupt pulse |
| fetch_addr_o | output | ADDR_W | Address of the packet presented to fetch |
| flush_o | output | 1 | One-cycle pipeline flush |
| ret_addr_o | output | ADDR_W | Saved resume address |
| br_illegal_o | output | 1 | Branch inside delay slots was dropped |

## Verification
The bench builds the block with `SLOTS` = 6, a 32-bit address, a 7-bit advance and `RESET_ADDR` = 0x1000. With six slots, the end of the countdown can be reached with stalls and idle cycles mixed in between the slots. A second branch lands in slot one, and an interrupt is held across five remaining slots and resumes at an unaligned target. Back-to-back flushes arise from a return followed by a held request, and entry and return are driven under stall.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_SEQ  = 3'd1,
    SRC_BR   = 3'd2,
    SRC_IRQ  = 3'd3,
    SRC_RET  = 3'd4
  } flow_src_e;
endpackage

// File: rtl/flow_slot_ctr.sv
module flow_slot_ctr #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en_i,
  input  logic              br_taken_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  output logic              busy_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              illegal_o
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SLOTS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] tgt_q;
  logic              cnt_en, tgt_en;

  always_comb begin
    busy_o     = (cnt_q != '0);
    redirect_o = adv_en_i && (cnt_q == CNT_ONE);
    illegal_o  = adv_en_i && br_taken_i && busy_o;
    cnt_en     = adv_en_i;
    tgt_en     = adv_en_i && br_taken_i && !busy_o;
    if (busy_o)          cnt_d = cnt_q - CNT_ONE;
    else if (br_taken_i) cnt_d = CNT_LOAD;
    else                 cnt_d = '0;
    tgt_o      = tgt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= br_tgt_i;
  end

  // R3
  last_slot_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (cnt_q == '0));
  // R3
  branch_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en_i && br_taken_i && !busy_o) |=> (cnt_q == CNT_LOAD));
  // R5
  illegal_keeps_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> $stable(tgt_q));
  // R4
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);
endmodule

// File: rtl/flow_irq_ctl.sv
module flow_irq_ctl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic [ADDR_W-1:0] irq_vec_i,
  input  logic              irq_ret_i,
  input  logic              slots_busy_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  output logic              enter_o,
  output logic              leave_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              in_isr_o
);
  logic              irq_pend_q, irq_pend_d;
  logic              ret_pend_q, ret_pend_d;
  logic              in_isr_q, in_isr_d;
  logic [ADDR_W-1:0] vec_q, vec_d;
  logic [ADDR_W-1:0] ret_q;
  logic              want_irq, want_ret, vec_en;

  always_comb begin
    want_irq   = irq_pend_q || irq_req_i;
    want_ret   = in_isr_q && (ret_pend_q || irq_ret_i);
    enter_o    = want_irq && !in_isr_q && !slots_busy_i;
    leave_o    = want_ret && !slots_busy_i;
    vec_o      = irq_pend_q ? vec_q : irq_vec_i;
    irq_pend_d = want_irq && !enter_o;
    ret_pend_d = want_ret && !leave_o;
    vec_en     = irq_req_i && !irq_pend_q;
    vec_d      = irq_vec_i;
    in_isr_d   = in_isr_q;
    if (enter_o) in_isr_d = 1'b1;
    if (leave_o) in_isr_d = 1'b0;
    ret_addr_o = ret_q;
    in_isr_o   = in_isr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend_q <= 1'b0;
      ret_pend_q <= 1'b0;
      in_isr_q   <= 1'b0;
    end else begin
      irq_pend_q <= irq_pend_d;
      ret_pend_q <= ret_pend_d;
      in_isr_q   <= in_isr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ret_q <= '0;
    else if (enter_o) ret_q <= cur_pc_i;
  end

  // R6
  resume_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_isr_q) |-> (ret_q == $past(cur_pc_i)));
  // R9
  resume_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_isr_q && $past(in_isr_q)) |-> $stable(ret_q));
  // R7
  entry_after_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_isr_q) |-> $past(!slots_busy_i));
endmodule

// File: rtl/flow_pc_reg.sv
module flow_pc_reg
  import flow_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                ADV_W      = 7,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  flow_src_e         sel_i,
  input  logic [ADV_W-1:0]  adv_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [ADDR_W-1:0] vec_i,
  input  logic [ADDR_W-1:0] ret_i,
  input  logic              illegal_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              flush_o,
  output logic              illegal_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              pc_en;
  logic              flush_q, flush_d;
  logic              ill_q;

  always_comb begin
    pc_en   = (sel_i != SRC_HOLD);
    flush_d = (sel_i == SRC_IRQ) || (sel_i == SRC_RET);
    unique case (sel_i)
      SRC_SEQ: pc_d = pc_q + ADDR_W'(adv_i);
      SRC_BR:  pc_d = tgt_i;
      SRC_IRQ: pc_d = vec_i;
      SRC_RET: pc_d = ret_i;
      default: pc_d = pc_q;
    endcase
    pc_o      = pc_q;
    flush_o   = flush_q;
    illegal_o = ill_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_ADDR;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      flush_q <= flush_d;
      ill_q   <= illegal_i;
    end
  end
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                ADV_W      = 7,
  parameter int                SLOTS      = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(32'h0000_1000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              disp_i,
  input  logic [ADV_W-1:0]  adv_i,
  input  logic              br_taken_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  input  logic              irq_req_i,
  input  logic [ADDR_W-1:0] irq_vec_i,
  input  logic              irq_ret_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              br_illegal_o
);
  logic              adv_en, slot_busy, slot_redirect, slot_illegal;
  logic [ADDR_W-1:0] slot_tgt, vec, ret_addr;
  logic              irq_enter, irq_leave, in_isr;
  flow_src_e         sel;

  always_comb begin
    adv_en = disp_i && !stall_i && !irq_enter && !irq_leave;
    if (irq_enter)          sel = SRC_IRQ;
    else if (irq_leave)     sel = SRC_RET;
    else if (slot_redirect) sel = SRC_BR;
    else if (adv_en)        sel = SRC_SEQ;
    else                    sel = SRC_HOLD;
  end

  flow_slot_ctr #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_en_i   (adv_en),
    .br_taken_i (br_taken_i),
    .br_tgt_i   (br_tgt_i),
    .busy_o     (slot_busy),
    .redirect_o (slot_redirect),
    .tgt_o      (slot_tgt),
    .illegal_o  (slot_illegal)
  );

  flow_irq_ctl #(.ADDR_W(ADDR_W)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req_i    (irq_req_i),
    .irq_vec_i    (irq_vec_i),
    .irq_ret_i    (irq_ret_i),
    .slots_busy_i (slot_busy),
    .cur_pc_i     (fetch_addr_o),
    .enter_o      (irq_enter),
    .leave_o      (irq_leave),
    .vec_o        (vec),
    .ret_addr_o   (ret_addr),
    .in_isr_o     (in_isr)
  );

  flow_pc_reg #(.ADDR_W(ADDR_W), .ADV_W(ADV_W), .RESET_ADDR(RESET_ADDR)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel),
    .adv_i     (adv_i),
    .tgt_i     (slot_tgt),
    .vec_i     (vec),
    .ret_i     (ret_addr),
    .illegal_i (slot_illegal),
    .pc_o      (fetch_addr_o),
    .flush_o   (flush_o),
    .illegal_o (br_illegal_o)
  );

  assign ret_addr_o = ret_addr;

  // R4
  stall_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !irq_enter && !irq_leave) |=> $stable(fetch_addr_o));
  // R11
  flush_marks_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (in_isr != $past(in_isr)));
  // R11
  mode_change_flushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_isr != $past(in_isr)) |-> flush_o);
  // R6
  entry_goes_to_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_isr) |-> (fetch_addr_o == $past(vec)));
  // R8
  return_goes_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_isr) |-> (fetch_addr_o == ret_addr_o));
  // R5
  illegal_only_in_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_illegal_o |-> $past(slot_busy));
endmodule

// File: tb/tb_flow_seq.sv
`timescale 1ns/1ps
module tb_flow_seq;
  localparam int AW = 32;
  localparam int VW = 7;

  typedef struct packed {
    logic          d;
    logic          s;
    logic          b;
    logic [AW-1:0] t;
    logic [VW-1:0] a;
    logic [AW-1:0] e;
  } vec_t;

  // walk: sequential advance, idle, stall and a six-slot branch to an unaligned target
  localparam vec_t VT [13] = '{
    '{1'b1, 1'b0, 1'b0, 32'h0,    7'd32, 32'h1020},
    '{1'b1, 1'b0, 1'b0, 32'h0,    7'd12, 32'h102C},
    '{1'b0, 1'b0, 1'b0, 32'h0,    7'd12, 32'h102C},
    '{1'b1, 1'b0, 1'b1, 32'h2004, 7'd8,  32'h1034},
    '{1'b1, 1'b0, 1'b0, 32'h0,    7'd4,  32'h1038},
    '{1'b1, 1'b1, 1'b0, 32'h0,    7'd4,  32'h1038},
    '{1'b1, 1'b0, 1'b0, 32'h0,    7'd16, 32'h1048},
    '{1'b1, 1'b0, 1'b0, 32'h0,    7'd8,  32'h1050},
    '{1'b1, 1'b0, 1'b0, 32'h0,    7'd8,  32'h1058},
    '{1'b0, 1'b0, 1'b0, 32'h0,    7'd8,  32'h1058},
    '{1'b1, 1'b0, 1'b0, 32'h0,    7'd4,  32'h105C},
    '{1'b1, 1'b0, 1'b0, 32'h0,    7'd20, 32'h2004},
    '{1'b1, 1'b0, 1'b0, 32'h0,    7'd36, 32'h2028}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall_i, disp_i, br_taken_i, irq_req_i, irq_ret_i;
  logic [VW-1:0] adv_i;
  logic [AW-1:0] br_tgt_i, irq_vec_i;
  logic [AW-1:0] fetch_addr_o, ret_addr_o;
  logic          flush_o, br_illegal_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flow_seq #(.ADDR_W(AW), .ADV_W(VW), .SLOTS(6), .RESET_ADDR(32'h1000)) dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .disp_i(disp_i), .adv_i(adv_i),
    .br_taken_i(br_taken_i), .br_tgt_i(br_tgt_i), .irq_req_i(irq_req_i),
    .irq_vec_i(irq_vec_i), .irq_ret_i(irq_ret_i), .fetch_addr_o(fetch_addr_o),
    .flush_o(flush_o), .ret_addr_o(ret_addr_o), .br_illegal_o(br_illegal_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic d, input logic s, input logic b, input logic [AW-1:0] t,
                     input logic [VW-1:0] a, input logic irq, input logic [AW-1:0] v,
                     input logic ret);
    disp_i = d; stall_i = s; br_taken_i = b; br_tgt_i = t; adv_i = a;
    irq_req_i = irq; irq_vec_i = v; irq_ret_i = ret;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    disp_i = 0; stall_i = 0; br_taken_i = 0; br_tgt_i = '0; adv_i = '0;
    irq_req_i = 0; irq_vec_i = '0; irq_ret_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 addr", fetch_addr_o, 32'h1000);
    chk("R1 flush", {31'd0, flush_o}, 32'd0);
    chk("R1 ret", ret_addr_o, 32'd0);
    chk("R1 illegal", {31'd0, br_illegal_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr after release", fetch_addr_o, 32'h1000);

    // R2 R3 R4 vector walk
    for (int i = 0; i < 13; i++) begin
      cyc(VT[i].d, VT[i].s, VT[i].b, VT[i].t, VT[i].a, 1'b0, '0, 1'b0);
      chk($sformatf("R2/R3/R4 vector %0d", i), fetch_addr_o, VT[i].e);
    end

    // R5 second branch inside delay slots
    cyc(1, 0, 1, 32'h5000, 7'd4, 0, '0, 0);
    chk("R3 branch packet advance", fetch_addr_o, 32'h202C);
    cyc(1, 0, 1, 32'h9000, 7'd4, 0, '0, 0);
    chk("R5 illegal flag", {31'd0, br_illegal_o}, 32'd1);
    chk("R5 slot advance", fetch_addr_o, 32'h2030);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, '0, 7'd4, 0, '0, 0);
    chk("R5 flag one cycle", {31'd0, br_illegal_o}, 32'd0);
    chk("R5 last slot addr", fetch_addr_o, 32'h2040);
    cyc(1, 0, 0, '0, 7'd4, 0, '0, 0);
    chk("R5 first target kept", fetch_addr_o, 32'h5000);

    // R8 return outside service ignored
    cyc(0, 0, 0, '0, 7'd4, 0, '0, 1);
    chk("R8 stray return addr", fetch_addr_o, 32'h5000);
    chk("R8 stray return flush", {31'd0, flush_o}, 32'd0);
    cyc(1, 0, 0, '0, 7'd8, 0, '0, 0);
    chk("R8 stray return later", fetch_addr_o, 32'h5008);

    // R6 interrupt entry, presented packet dropped
    cyc(1, 0, 0, '0, 7'd8, 1, 32'h8000, 0);
    chk("R6 flush", {31'd0, flush_o}, 32'd1);
    chk("R6 vector", fetch_addr_o, 32'h8000);
    chk("R6 resume", ret_addr_o, 32'h5008);
    cyc(1, 0, 0, '0, 7'd4, 0, '0, 0);
    chk("R11 flush single", {31'd0, flush_o}, 32'd0);
    chk("R2 isr advance", fetch_addr_o, 32'h8004);

    // R9 request during service held
    cyc(1, 0, 0, '0, 7'd4, 1, 32'h8800, 0);
    chk("R9 no flush in service", {31'd0, flush_o}, 32'd0);
    chk("R9 no redirect in service", fetch_addr_o, 32'h8008);
    cyc(0, 0, 0, '0, 7'd4, 0, '0, 1);
    chk("R8 return flush", {31'd0, flush_o}, 32'd1);
    chk("R8 return addr", fetch_addr_o, 32'h5008);
    cyc(0, 0, 0, '0, 7'd4, 0, '0, 0);
    chk("R9 held entry flush", {31'd0, flush_o}, 32'd1);
    chk("R9 held vector", fetch_addr_o, 32'h8800);
    chk("R9 resume", ret_addr_o, 32'h5008);
    cyc(0, 0, 0, '0, 7'd4, 0, '0, 0);
    chk("R11 flush drops", {31'd0, flush_o}, 32'd0);
    cyc(0, 0, 0, '0, 7'd4, 0, '0, 1);
    chk("R8 second return", fetch_addr_o, 32'h5008);

    // R7 interrupt during delay slots
    cyc(1, 0, 1, 32'h3003, 7'd8, 0, '0, 0);
    cyc(1, 0, 0, '0, 7'd8, 1, 32'h8000, 0);
    chk("R7 held flush", {31'd0, flush_o}, 32'd0);
    chk("R7 held addr", fetch_addr_o, 32'h5018);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, '0, 7'd8, 0, '0, 0);
    chk("R7 slots sequential", fetch_addr_o, 32'h5038);
    cyc(1, 0, 0, '0, 7'd8, 0, '0, 0);
    chk("R7 target reached", fetch_addr_o, 32'h3003);
    chk("R7 no flush at target", {31'd0, flush_o}, 32'd0);
    cyc(0, 0, 0, '0, 7'd8, 0, '0, 0);
    chk("R7 entry flush", {31'd0, flush_o}, 32'd1);
    chk("R7 vector", fetch_addr_o, 32'h8000);
    chk("R7 resume target", ret_addr_o, 32'h3003);

    // R10 entry and return under stall
    cyc(1, 1, 0, '0, 7'd4, 0, '0, 1);
    chk("R10 return under stall", fetch_addr_o, 32'h3003);
    chk("R10 return flush", {31'd0, flush_o}, 32'd1);
    cyc(0, 1, 0, '0, 7'd4, 1, 32'h8400, 0);
    chk("R10 entry under stall", fetch_addr_o, 32'h8400);
    chk("R10 entry flush", {31'd0, flush_o}, 32'd1);
    cyc(1, 1, 0, '0, 7'd4, 0, '0, 0);
    chk("R4 stall holds", fetch_addr_o, 32'h8400);
    chk("R11 stall no flush", {31'd0, flush_o}, 32'd0);
    cyc(0, 0, 0, '0, 7'd4, 0, '0, 1);
    chk("R8 final return", fetch_addr_o, 32'h3003);

    finish_run();
  end
endmodule